// File: doc/BRIEF.md
# Receive Status Word Generator

This block sits beside an Ethernet receive path and watches the byte stream as it arrives. Each byte comes with a valid strobe, and start-of-frame and end-of-frame markers mark the first and last bytes. On the last byte the path also supplies its CRC-bad and alignment-error verdicts. A FIFO overflow flag may rise on any byte of the frame. The block is also given the local station address and two filter controls: promiscuous mode and broadcast acceptance.

While the frame streams through, the block counts its bytes and classifies the destination address. When the last byte arrives it decides whether to keep the frame. For a kept frame it emits, for one cycle, the 32-bit status word that a DMA engine writes back into the receive descriptor. In that word the ownership bit is cleared, and the word carries the length, the destination class, per-cause error flags, an error summary and a good-frame flag. A frame that fails the address filter produces no word at all.

Top module: `rxs_status_gen`

## Requirements
- R1: Bit 31 (ownership) of every emitted word is 0. `stat_valid` is a one-cycle pulse in the cycle after the clock edge that samples the end-of-frame byte.
- R2: Bits 30:16 hold the number of valid bytes from the start-of-frame byte through the end-of-frame byte inclusive, FCS bytes included. The count saturates at 32767.
- R3: Exactly one of bits 13 (multicast), 12 (broadcast) and 11 (unicast) is set. Broadcast means the first six bytes are all 0xFF. Multicast means bit 0 of the first byte is 1 and the frame is not broadcast. Any other frame is unicast, including a frame shorter than six bytes.
- R4: With `promisc` set, every frame is kept. Otherwise a frame is kept only if it is unicast and its six destination bytes equal `station_addr`, or if it is broadcast and `accept_bcast` is set. Byte 0 of `station_addr` sits in bits 7:0 and is compared with the first byte on the wire. A dropped frame emits no word.
- R5: Bit 5 (runt) is set when the length is below 64. Bit 4 (too long) is set when the length exceeds 1536.
- R6: Bit 1 (CRC error) and bit 2 (alignment error) copy `in_crc_bad` and `in_align_err` as sampled with the end-of-frame byte. Bit 3 (overflow) is set if `in_fifo_ovf` was high with any valid byte of the frame.
- R7: Bit 0 is the OR of bits 5 to 1. Bit 15 (good frame) is the inverse of bit 0.
- R8: Bits 9 and 8 (first and last segment) are both 1. Bits 14, 10, 7 and 6 are 0.
- R9: Cycles with `in_valid` low are ignored, whatever the other inputs carry. Valid bytes that arrive outside a frame and are not marked as start of frame are ignored. A start of frame in the middle of a frame restarts the count and the classification.
- R10: After reset, `stat_valid` is 0 and `stat_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_crc_bad | input | 1 | CRC verdict, sampled with the last byte |
| in_align_err | input | 1 | Alignment verdict, sampled with the last byte |
| in_fifo_ovf | input | 1 | Overflow seen on this byte |
| station_addr | input | 48 | Local address, first wire byte in bits 7:0 |
| promisc | input | 1 | Keep every frame |
| accept_bcast | input | 1 | Keep broadcast frames |
| stat_valid | output | 1 | Status word strobe |
| stat_word | output | 32 | Receive status word |

## Verification
Address classification and frame closure can fall in the same cycle. This happens when the sixth destination byte is also the end-of-frame byte: the broadcast decision, the filter decision and the runt flag must then all use that final byte rather than the registered state. The bench provokes this with a six-byte all-ones frame and with a three-byte all-ones frame, where the address is never complete. It also raises overflow on the end-of-frame byte and places a new start of frame directly after an end of frame. The scoreboard judges each emitted word field by field against a model of the requirements.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int LEN_W = 15;

    typedef logic [LEN_W-1:0] len_t;

    // Bit layout of the descriptor status word, MSB first.
    typedef struct packed {
        logic       owned;
        len_t       len;
        logic       good;
        logic       rsv14;
        logic       mcast;
        logic       bcast;
        logic       ucast;
        logic       rsv10;
        logic       first;
        logic       last;
        logic [1:0] rsv76;
        logic       runt;
        logic       toolong;
        logic       ovf;
        logic       align;
        logic       crc;
        logic       err;
    } rx_status_t;

    typedef struct packed {
        logic runt;
        logic toolong;
        logic ovf;
        logic align;
        logic crc;
    } rx_err_t;

    typedef struct packed {
        logic mcast;
        logic bcast;
        logic ucast;
    } dst_class_t;

    function automatic dst_class_t classify(input logic all_ones, input logic group_bit);
        dst_class_t c;
        c.bcast = all_ones;
        c.mcast = group_bit & ~all_ones;
        c.ucast = ~group_bit & ~all_ones;
        return c;
    endfunction

    function automatic rx_status_t build_status(input len_t len, input dst_class_t cls,
                                                input rx_err_t e);
        rx_status_t s;
        s         = '0;
        s.owned   = 1'b0;
        s.len     = len;
        s.mcast   = cls.mcast;
        s.bcast   = cls.bcast;
        s.ucast   = cls.ucast;
        s.first   = 1'b1;
        s.last    = 1'b1;
        s.runt    = e.runt;
        s.toolong = e.toolong;
        s.ovf     = e.ovf;
        s.align   = e.align;
        s.crc     = e.crc;
        s.err     = |e;
        s.good    = ~(|e);
        return s;
    endfunction

endpackage

// File: rtl/rxs_len_track.sv
module rxs_len_track
    import rxs_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1536
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic restart,
    output len_t cur_idx,
    output len_t cur_len,
    output logic is_runt,
    output logic is_long
);
    localparam len_t SAT = '1;

    len_t cnt;

    always_comb begin
        cur_idx = restart ? '0 : cnt;
        cur_len = (cur_idx == SAT) ? SAT : cur_idx + 1'b1;
        is_runt = cur_len < len_t'(MIN_LEN);
        is_long = cur_len > len_t'(MAX_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (take) cnt <= cur_len;
    end

endmodule

// File: rtl/rxs_dst_match.sv
module rxs_dst_match
    import rxs_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  len_t                    cur_idx,
    input  logic [7:0]              in_byte,
    input  logic [ADDR_BYTES*8-1:0] station,
    output logic                    addr_done,
    output logic                    match_n,
    output logic                    ones_n,
    output logic                    group_n
);
    localparam int AIW   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int SLOTS = 1 << AIW;

    logic [SLOTS-1:0] slot_eq;
    logic             match_r, ones_r, group_r;
    logic             in_addr, first;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < ADDR_BYTES) begin : g_real
            assign slot_eq[i] = (in_byte == station[8*i +: 8]);
        end else begin : g_pad
            assign slot_eq[i] = 1'b0;
        end
    end

    always_comb begin
        in_addr   = cur_idx < len_t'(ADDR_BYTES);
        first     = (cur_idx == '0);
        addr_done = cur_idx >= len_t'(ADDR_BYTES - 1);
        match_n   = in_addr ? ((first | match_r) & slot_eq[cur_idx[AIW-1:0]]) : match_r;
        ones_n    = in_addr ? ((first | ones_r) & (in_byte == 8'hFF)) : ones_r;
        group_n   = first ? in_byte[0] : group_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_r <= 1'b0;
            ones_r  <= 1'b0;
            group_r <= 1'b0;
        end else if (take) begin
            match_r <= match_n;
            ones_r  <= ones_n;
            group_r <= group_n;
        end
    end

endmodule

// File: rtl/rxs_status_gen.sv
module rxs_status_gen
    import rxs_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1536
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [7:0]              in_byte,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic                    in_crc_bad,
    input  logic                    in_align_err,
    input  logic                    in_fifo_ovf,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic                    promisc,
    input  logic                    accept_bcast,
    output logic                    stat_valid,
    output logic [31:0]             stat_word
);
    logic       in_frame, ovf_r;
    logic       restart, take, close, keep, ovf_n;
    len_t       cur_idx, cur_len;
    logic       is_runt, is_long;
    logic       addr_done, match_n, ones_n, group_n;
    dst_class_t cls;
    rx_err_t    errs;
    rx_status_t st;

    assign restart = in_valid & in_sof;
    assign take    = in_valid & (in_sof | in_frame);
    assign close   = take & in_eof;

    rxs_len_track #(
        .MIN_LEN (MIN_FRAME),
        .MAX_LEN (MAX_FRAME)
    ) u_len (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .restart (restart),
        .cur_idx (cur_idx),
        .cur_len (cur_len),
        .is_runt (is_runt),
        .is_long (is_long)
    );

    rxs_dst_match #(
        .ADDR_BYTES (ADDR_BYTES)
    ) u_dst (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .cur_idx   (cur_idx),
        .in_byte   (in_byte),
        .station   (station_addr),
        .addr_done (addr_done),
        .match_n   (match_n),
        .ones_n    (ones_n),
        .group_n   (group_n)
    );

    always_comb begin
        ovf_n        = in_fifo_ovf | (~restart & ovf_r);
        cls          = classify(ones_n & addr_done, group_n);
        keep         = promisc | (cls.ucast & match_n & addr_done) | (cls.bcast & accept_bcast);
        errs.runt    = is_runt;
        errs.toolong = is_long;
        errs.ovf     = ovf_n;
        errs.align   = in_align_err;
        errs.crc     = in_crc_bad;
        st           = build_status(cur_len, cls, errs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            ovf_r      <= 1'b0;
            stat_valid <= 1'b0;
            stat_word  <= '0;
        end else begin
            stat_valid <= close & keep;
            if (close & keep) stat_word <= st;
            if (take) begin
                ovf_r    <= ovf_n;
                in_frame <= ~in_eof;
            end
        end
    end

endmodule

// File: rtl/rxs_status_gen_chk.sv
module rxs_status_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_eof,
    input logic        promisc,
    input logic        accept_bcast,
    input logic        stat_valid,
    input logic [31:0] stat_word
);
    assert_owner_clear_R1: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !stat_word[31]);

    assert_after_eof_R1: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $past(in_valid && in_eof));

    assert_one_class_R3: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $countones(stat_word[13:11]) == 1);

    assert_mcast_needs_promisc_R4: assert property (@(posedge clk) disable iff (rst)
        stat_valid && stat_word[13] |-> $past(promisc));

    assert_bcast_allowed_R4: assert property (@(posedge clk) disable iff (rst)
        stat_valid && stat_word[12] |-> $past(promisc || accept_bcast));

    assert_size_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !(stat_word[5] && stat_word[4]));

    assert_summary_R7: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_word[0] == (|stat_word[5:1])) && (stat_word[15] != stat_word[0]));

    assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> stat_word[9] && stat_word[8] && !stat_word[14] && !stat_word[10]
                       && stat_word[7:6] == 2'b00);
endmodule

bind rxs_status_gen rxs_status_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_eof       (in_eof),
    .promisc      (promisc),
    .accept_bcast (accept_bcast),
    .stat_valid   (stat_valid),
    .stat_word    (stat_word)
);

// File: tb/rxs_status_gen_test.sv
`timescale 1ns/1ps
module rxs_status_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_crc_bad = 1'b0, in_align_err = 1'b0, in_fifo_ovf = 1'b0;
    logic [47:0] sta = 48'h6655_4433_2210;
    logic        promisc = 1'b0, accept_bcast = 1'b0;
    logic        stat_valid;
    logic [31:0] stat_word;

    int errors = 0, checks = 0;
    int cyc = 0, eof_cyc = -10;
    logic [31:0] exp_q[$];
    logic [7:0]  fb[0:2047];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rxs_status_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_sof(in_sof), .in_eof(in_eof), .in_crc_bad(in_crc_bad),
        .in_align_err(in_align_err), .in_fifo_ovf(in_fifo_ovf),
        .station_addr(sta), .promisc(promisc), .accept_bcast(accept_bcast),
        .stat_valid(stat_valid), .stat_word(stat_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // kind 0: station, 1: broadcast, 2: multicast, 3: foreign unicast
    task automatic fill(input int kind, input int n);
        for (int i = 0; i < n; i++) fb[i] = 8'((i * 7 + 3) & 8'hFF);
        for (int i = 0; i < 6; i++) begin
            case (kind)
                0: fb[i] = sta[8*i +: 8];
                1: fb[i] = 8'hFF;
                2: fb[i] = (i == 0) ? 8'h01 : 8'(8'h20 + i);
                default: fb[i] = (i == 5) ? 8'h99 : sta[8*i +: 8];
            endcase
        end
    endtask

    function automatic logic [32:0] model(input int n, input bit crc, input bit al, input bit ovf);
        logic bc, mc, uc, match, acc, runt, lng, err;
        logic [14:0] len;
        bc = (n >= 6);
        match = (n >= 6);
        for (int i = 0; i < 6; i++) begin
            if (i < n) begin
                if (fb[i] != 8'hFF) bc = 1'b0;
                if (fb[i] != sta[8*i +: 8]) match = 1'b0;
            end
        end
        mc   = fb[0][0] & ~bc;
        uc   = ~mc & ~bc;
        acc  = promisc | (uc & match) | (bc & accept_bcast);
        runt = n < 64;
        lng  = n > 1536;
        err  = runt | lng | ovf | al | crc;
        len  = 15'(n);
        return {acc, 1'b0, len, ~err, 1'b0, mc, bc, uc, 1'b0, 2'b11, 2'b00,
                runt, lng, ovf, al, crc, err};
    endfunction

    task automatic idle(input int k);
        in_valid = 0; in_sof = 0; in_eof = 0; in_crc_bad = 0; in_align_err = 0; in_fifo_ovf = 0;
        repeat (k) @(negedge clk);
    endtask

    // Drives one frame from fb; the expected word is queued when the frame is kept.
    task automatic send(input int n, input bit crc, input bit al, input int ovf_at, input int gap);
        logic [32:0] m;
        m = model(n, crc, al, ovf_at >= 0 && ovf_at < n);
        if (m[32]) exp_q.push_back(m[31:0]);
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_byte = fb[i]; in_sof = (i == 0); in_eof = (i == n - 1);
            in_crc_bad = (i == n - 1) & crc; in_align_err = (i == n - 1) & al;
            in_fifo_ovf = (i == ovf_at);
            if (i == n - 1) eof_cyc = cyc;
            @(negedge clk);
            if (gap > 0 && (i % gap) == gap - 1 && i != n - 1) begin
                // R9: junk on every line while the strobe is low
                in_valid = 0; in_byte = 8'hA5; in_sof = 1; in_eof = 1;
                in_crc_bad = 1; in_align_err = 1; in_fifo_ovf = 1;
                @(negedge clk);
            end
        end
    endtask

    // Valid bytes without start of frame, or an unterminated start.
    task automatic loose(input int n, input bit with_sof, input bit with_eof);
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_byte = 8'(i); in_sof = with_sof && (i == 0);
            in_eof = with_eof && (i == n - 1);
            in_crc_bad = 1; in_align_err = 0; in_fifo_ovf = 1;
            @(negedge clk);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && stat_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4/R9: unexpected status actual=%h expected=none", stat_word);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk("R1 owner", {31'd0, stat_word[31]}, {31'd0, e[31]});
                chk("R1 timing", cyc, eof_cyc + 1);
                chk("R2 length", {17'd0, stat_word[30:16]}, {17'd0, e[30:16]});
                chk("R3 class", {29'd0, stat_word[13:11]}, {29'd0, e[13:11]});
                chk("R5 size flags", {30'd0, stat_word[5:4]}, {30'd0, e[5:4]});
                chk("R6 error flags", {29'd0, stat_word[3:1]}, {29'd0, e[3:1]});
                chk("R7 summary", {30'd0, stat_word[15], stat_word[0]}, {30'd0, e[15], e[0]});
                chk("R8 fixed bits", {26'd0, stat_word[14], stat_word[10:6]},
                                     {26'd0, e[14], e[10:6]});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'd0, stat_valid}, 32'd0);
        chk("R10 reset word", stat_word, 32'd0);
        rst = 0;
        @(negedge clk);

        fill(0, 64);   send(64, 0, 0, -1, 0);  idle(2);          // R4 station match, clean
        fill(0, 63);   send(63, 0, 0, -1, 0);  idle(2);          // R5 runt boundary
        fill(0, 1536); send(1536, 0, 0, -1, 0); idle(2);         // R5 longest clean
        fill(0, 1537); send(1537, 0, 0, -1, 0); idle(2);         // R5 too long
        accept_bcast = 1;
        fill(1, 80);   send(80, 0, 0, -1, 0);  idle(2);          // R3 broadcast kept
        accept_bcast = 0;
        fill(1, 80);   send(80, 0, 0, -1, 0);  idle(2);          // R4 broadcast dropped
        fill(2, 70);   send(70, 0, 0, -1, 0);  idle(2);          // R4 multicast dropped
        fill(3, 70);   send(70, 0, 0, -1, 0);  idle(2);          // R4 foreign unicast dropped
        promisc = 1;
        fill(2, 70);   send(70, 0, 0, -1, 0);  idle(2);          // R3 multicast under promisc
        fill(3, 70);   send(70, 0, 0, -1, 0);  idle(2);          // R4 promisc keeps foreign
        fill(1, 6);    send(6, 0, 0, -1, 0);   idle(2);          // R3 address completes on eof
        fill(1, 3);    send(3, 0, 0, -1, 0);   idle(2);          // R3 short all-ones is multicast
        promisc = 0;
        fill(0, 100);  send(100, 1, 0, -1, 0); idle(1);          // R6 CRC
        fill(0, 100);  send(100, 0, 1, 40, 0);                   // R6 align + mid overflow
        fill(0, 65);   send(65, 0, 0, 64, 0);  idle(2);          // R6 overflow on eof, back-to-back
        fill(0, 90);   send(90, 0, 0, -1, 3);  idle(2);          // R9 gaps with junk
        loose(20, 0, 1); idle(2);                                // R9 stray bytes ignored
        loose(30, 1, 0);                                         // R9 unterminated start
        fill(0, 72);   send(72, 0, 0, -1, 0);  idle(4);          // R9 restart counts afresh

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4: missing statuses actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule